// File: doc/BRIEF.md
# Clock Reference Source Selector

This block picks one timing reference out of a set of candidate inputs and reports which one it chose. The candidates are external building-timing ports, clocks recovered from receive lines, and clocks derived from packet timing. Each candidate presents a qualified valid flag, a 4-bit quality code, an 8-bit local priority, a 2-bit source type and a 4-bit source number. When no candidate may be used, the block falls back to the local oscillator.

In automatic mode the winner is found by ranking the candidates on a fixed sequence of keys. The quality code counts first, and only when quality use is switched on. The priority value comes next, then the source type, then the source number, and last the candidate index. Selection is revertive, so a better candidate that comes back takes over at once. In manual mode the forced index is held whatever the candidates do. The result is registered one clock after the inputs. A one-cycle pulse marks every change of the selected index.

Top module: `clk_ref_selector`

## Requirements
- R1: While `rst` is high and after it is released, until the first evaluation, `sel_idx` = N_SRC, `sel_local` = 1, `sel_ql` = LOCAL_QL and `sel_change` = 0.
- R2: A candidate is eligible only if its valid bit is 1, its priority is not 255, its type is not 3 and its quality code is not 0xF (do-not-use). An ineligible candidate is never chosen in automatic mode, whether quality use is on or off.
- R3: With `ql_enable` = 1 the candidate with the best quality rank wins. The ranks from best to worst are 0x2, 0x4, 0x8, 0xB, 0x0 (unknown), then any other code.
- R4: With `ql_enable` = 0 the quality code has no effect on the ranking, apart from the exclusion in R2.
- R5: Among candidates tied on the quality key, the lowest priority value wins.
- R6: Among candidates tied on priority, type 0 (external port) beats type 1 (line) and type 1 beats type 2 (packet). On a type tie the lower source number wins, and on a full tie the lower candidate index wins.
- R7: When no candidate is eligible in automatic mode, `sel_idx` = N_SRC, `sel_local` = 1 and `sel_ql` = LOCAL_QL.
- R8: With `manual_mode` = 1, `sel_idx` follows `forced_idx` even when that candidate is invalid or a better one exists, and `sel_ql` shows that candidate's quality code. A forced index of N_SRC or more selects the local oscillator.
- R9: Selection is revertive. When a better candidate becomes eligible again, it replaces the current one.
- R10: The outputs reflect the inputs of the previous clock edge. `sel_change` is high for exactly the one cycle in which `sel_idx` differs from its prior value, and it stays low when the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| manual_mode | input | 1 | 1 = hold forced index, 0 = automatic ranking |
| ql_enable | input | 1 | 1 = rank on quality code first |
| forced_idx | input | IDXW | Index used in manual mode |
| cand_valid | input | N_SRC | Per-candidate qualified valid |
| cand_ql | input | N_SRC*4 | Per-candidate quality code |
| cand_prio | input | N_SRC*8 | Per-candidate priority, 255 = unconfigured |
| cand_type | input | N_SRC*2 | Per-candidate source type |
| cand_num | input | N_SRC*4 | Per-candidate source number |
| sel_idx | output | IDXW | Selected index, N_SRC = local oscillator |
| sel_local | output | 1 | Fallback-to-local flag |
| sel_ql | output | 4 | Quality code of the selection |
| sel_change | output | 1 | One-cycle pulse on index change |

## Verification
The bench sets up candidates that tie on every key except one. A design that compares keys in the wrong order, or that lets a later index win a full tie, then picks a different winner. It offers a do-not-use candidate with the best priority while quality use is off, which catches a design that applies the exclusion only when quality use is on. It also offers a bare unknown code, which catches a design that ranks unknown above SEC or treats it as excluded. It withdraws and restores a better candidate, which exposes a selector that is not revertive. It invalidates a forced source in manual mode, which exposes one that quietly reselects. It checks the change pulse across repeated equal results, where a level-based pulse would stay high.

// File: rtl/clk_ref_selector.sv
module clk_ref_selector #(
  parameter int N_SRC = 8,
  parameter int QLW = 4,
  parameter int PRIW = 8,
  parameter int TYPW = 2,
  parameter int NUMW = 4,
  parameter logic [3:0] LOCAL_QL = 4'hB,
  localparam int IDXW = $clog2(N_SRC + 1),
  localparam int KEYW = 3 + PRIW + TYPW + NUMW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   manual_mode,
  input  logic                   ql_enable,
  input  logic [IDXW-1:0]        forced_idx,
  input  logic [N_SRC-1:0]       cand_valid,
  input  logic [N_SRC*QLW-1:0]   cand_ql,
  input  logic [N_SRC*PRIW-1:0]  cand_prio,
  input  logic [N_SRC*TYPW-1:0]  cand_type,
  input  logic [N_SRC*NUMW-1:0]  cand_num,
  output logic [IDXW-1:0]        sel_idx,
  output logic                   sel_local,
  output logic [3:0]             sel_ql,
  output logic                   sel_change
);
  localparam logic [IDXW-1:0] LOC_IDX = IDXW'(N_SRC);

  function automatic logic [2:0] ql_rank(input logic [3:0] q);
    case (q)
      4'h2:    ql_rank = 3'd0;
      4'h4:    ql_rank = 3'd1;
      4'h8:    ql_rank = 3'd2;
      4'hB:    ql_rank = 3'd3;
      4'h0:    ql_rank = 3'd4;
      default: ql_rank = 3'd5;
    endcase
  endfunction

  logic            found;
  logic [KEYW-1:0] best_key;
  logic [IDXW-1:0] best_idx;
  logic [IDXW-1:0] nxt_idx;
  logic            nxt_local;
  logic [3:0]      nxt_ql;
  int              nxt_c;

  always_comb begin
    found    = 1'b0;
    best_key = '1;
    best_idx = LOC_IDX;
    for (int i = 0; i < N_SRC; i++) begin
      logic [QLW-1:0]  q;
      logic [PRIW-1:0] p;
      logic [TYPW-1:0] t;
      logic [KEYW-1:0] k;
      logic            ok;
      q  = cand_ql[i*QLW +: QLW];
      p  = cand_prio[i*PRIW +: PRIW];
      t  = cand_type[i*TYPW +: TYPW];
      ok = cand_valid[i] && (p != '1) && (t != 2'd3) && (q != 4'hF);
      k  = {(ql_enable ? ql_rank(q) : 3'd0), p, t, cand_num[i*NUMW +: NUMW]};
      if (ok && (!found || k < best_key)) begin
        found    = 1'b1;
        best_key = k;
        best_idx = IDXW'(i);
      end
    end
  end

  assign nxt_idx   = manual_mode ? ((forced_idx < LOC_IDX) ? forced_idx : LOC_IDX)
                                 : (found ? best_idx : LOC_IDX);
  assign nxt_local = (nxt_idx == LOC_IDX);
  assign nxt_c     = nxt_local ? 0 : int'(nxt_idx);
  assign nxt_ql    = nxt_local ? LOCAL_QL : cand_ql[nxt_c*QLW +: 4];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx    <= LOC_IDX;
      sel_local  <= 1'b1;
      sel_ql     <= LOCAL_QL;
      sel_change <= 1'b0;
    end else begin
      sel_idx    <= nxt_idx;
      sel_local  <= nxt_local;
      sel_ql     <= nxt_ql;
      sel_change <= (nxt_idx != sel_idx);
    end
  end

  logic                  manual_d;
  logic [IDXW-1:0]       forced_d;
  logic [N_SRC-1:0]      valid_d;
  logic [N_SRC*PRIW-1:0] prio_d;
  int                    sc;

  always_ff @(posedge clk) begin
    if (rst) begin
      manual_d <= 1'b0;
      forced_d <= '0;
      valid_d  <= '0;
      prio_d   <= '0;
    end else begin
      manual_d <= manual_mode;
      forced_d <= forced_idx;
      valid_d  <= cand_valid;
      prio_d   <= cand_prio;
    end
  end

  assign sc = sel_local ? 0 : int'(sel_idx);

  assert_manual_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (manual_d && forced_d < LOC_IDX) |-> sel_idx == forced_d);

  assert_auto_valid_R2: assert property (@(posedge clk) disable iff (rst)
    (!manual_d && !sel_local) |-> valid_d[sc]);

  assert_auto_prio_R2: assert property (@(posedge clk) disable iff (rst)
    (!manual_d && !sel_local) |-> prio_d[sc*PRIW +: PRIW] != '1);

  assert_no_dnu_R2: assert property (@(posedge clk) disable iff (rst)
    (!manual_d && !sel_local) |-> sel_ql != 4'hF);

  assert_local_ql_R7: assert property (@(posedge clk) disable iff (rst)
    sel_local |-> sel_ql == LOCAL_QL);
endmodule

// File: tb/clk_ref_selector_test.sv
`timescale 1ns/1ps
module clk_ref_selector_test;
  localparam int N = 4;
  localparam int IW = 3;

  logic clk = 0, rst = 1, manual_mode = 0, ql_enable = 0;
  logic [IW-1:0] forced_idx = '0;
  logic [N-1:0] cand_valid = '0;
  logic [N*4-1:0] cand_ql = '0;
  logic [N*8-1:0] cand_prio = '0;
  logic [N*2-1:0] cand_type = '0;
  logic [N*4-1:0] cand_num = '0;
  logic [IW-1:0] sel_idx;
  logic sel_local, sel_change;
  logic [3:0] sel_ql;

  int tests = 0, fails = 0;
  logic [IW-1:0] prev_idx;

  always #2.5 clk = ~clk;

  clk_ref_selector #(.N_SRC(N)) uut (
    .clk(clk), .rst(rst), .manual_mode(manual_mode), .ql_enable(ql_enable),
    .forced_idx(forced_idx), .cand_valid(cand_valid), .cand_ql(cand_ql),
    .cand_prio(cand_prio), .cand_type(cand_type), .cand_num(cand_num),
    .sel_idx(sel_idx), .sel_local(sel_local), .sel_ql(sel_ql), .sel_change(sel_change));

  // {ql_en, s0, s1, s2, s3, exp_idx, exp_ql}; source = {valid, ql, prio, type, num}
  localparam logic [83:0] VEC [13] = '{
    {1'b1, 19'd0, 19'd0, 19'd0, 19'd0, 3'd4, 4'hB},
    {1'b1, 1'b1,4'hB,8'd10,2'd0,4'd0, 1'b1,4'h2,8'd50,2'd1,4'd0, 19'd0, 19'd0, 3'd1, 4'h2},
    {1'b0, 1'b1,4'hB,8'd10,2'd0,4'd0, 1'b1,4'h2,8'd50,2'd1,4'd0, 19'd0, 19'd0, 3'd0, 4'hB},
    {1'b1, 1'b1,4'h4,8'd20,2'd2,4'd0, 1'b1,4'h4,8'd20,2'd1,4'd5, 1'b1,4'h4,8'd20,2'd1,4'd3, 19'd0, 3'd2, 4'h4},
    {1'b0, 1'b1,4'hF,8'd1,2'd0,4'd0, 1'b1,4'h8,8'd9,2'd2,4'd0, 19'd0, 19'd0, 3'd1, 4'h8},
    {1'b1, 1'b1,4'h2,8'd255,2'd0,4'd0, 1'b1,4'hB,8'd200,2'd1,4'd0, 19'd0, 19'd0, 3'd1, 4'hB},
    {1'b1, 1'b1,4'h0,8'd1,2'd0,4'd0, 1'b1,4'hB,8'd100,2'd0,4'd0, 19'd0, 19'd0, 3'd1, 4'hB},
    {1'b1, 1'b1,4'h0,8'd5,2'd1,4'd0, 1'b1,4'hF,8'd1,2'd0,4'd0, 19'd0, 19'd0, 3'd0, 4'h0},
    {1'b1, 19'd0, 19'd0, 1'b1,4'h8,8'd7,2'd0,4'd2, 1'b1,4'h8,8'd7,2'd0,4'd2, 3'd2, 4'h8},
    {1'b0, 1'b1,4'h2,8'd30,2'd0,4'd0, 1'b1,4'hB,8'd20,2'd0,4'd0, 19'd0, 19'd0, 3'd1, 4'hB},
    {1'b1, 1'b1,4'h2,8'd30,2'd0,4'd0, 1'b1,4'hB,8'd20,2'd0,4'd0, 19'd0, 19'd0, 3'd0, 4'h2},
    {1'b1, 1'b1,4'h2,8'd1,2'd3,4'd0, 19'd0, 19'd0, 19'd0, 3'd4, 4'hB},
    {1'b0, 1'b1,4'h2,8'd255,2'd0,4'd0, 1'b1,4'h8,8'd255,2'd1,4'd1, 19'd0, 19'd0, 3'd4, 4'hB}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_src(input int i, input logic v, input logic [3:0] q,
                         input logic [7:0] p, input logic [1:0] t, input logic [3:0] n);
    cand_valid[i] = v;
    cand_ql[i*4 +: 4] = q;
    cand_prio[i*8 +: 8] = p;
    cand_type[i*2 +: 2] = t;
    cand_num[i*4 +: 4] = n;
  endtask

  task automatic expect_sel(input logic [IW-1:0] ei, input logic [3:0] eq, input string req);
    logic pulse;
    pulse = (ei != prev_idx);
    chk(sel_idx == ei, req, sel_idx, ei);
    chk(sel_local == (ei == 3'd4), req, sel_local, (ei == 3'd4));
    chk(sel_ql == eq, req, sel_ql, eq);
    chk(sel_change == pulse, "R10 pulse", sel_change, pulse);
    prev_idx = ei;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sel_idx == 3'd4, "R1 idx", sel_idx, 4);
    chk(sel_local == 1'b1, "R1 local", sel_local, 1);
    chk(sel_ql == 4'hB, "R1 ql", sel_ql, 11);
    chk(sel_change == 1'b0, "R1 pulse", sel_change, 0);
    rst = 0;
    prev_idx = 3'd4;

    // Table: R2 R3 R4 R5 R6 R7 R10
    for (int k = 0; k < 13; k++) begin
      logic [83:0] v;
      v = VEC[k];
      ql_enable = v[83];
      for (int i = 0; i < N; i++) begin
        logic [18:0] s;
        s = v[82-19*i -: 19];
        set_src(i, s[18], s[17:14], s[13:6], s[5:4], s[3:0]);
      end
      @(negedge clk);
      expect_sel(v[6:4], v[3:0], $sformatf("R3/R6 vector %0d", k));
    end

    // R9 revertive
    ql_enable = 1;
    for (int i = 0; i < N; i++) set_src(i, 0, 4'h0, 8'd0, 2'd0, 4'd0);
    set_src(0, 1, 4'h8, 8'd10, 2'd0, 4'd0);
    @(negedge clk); expect_sel(3'd0, 4'h8, "R9 start");
    set_src(1, 1, 4'h2, 8'd10, 2'd0, 4'd0);
    @(negedge clk); expect_sel(3'd1, 4'h2, "R9 better");
    @(negedge clk); expect_sel(3'd1, 4'h2, "R10 held");
    cand_valid[1] = 0;
    @(negedge clk); expect_sel(3'd0, 4'h8, "R9 loss");
    cand_valid[1] = 1;
    @(negedge clk); expect_sel(3'd1, 4'h2, "R9 revert");

    // R8 manual hold
    manual_mode = 1; forced_idx = 3'd0;
    @(negedge clk); expect_sel(3'd0, 4'h8, "R8 forced");
    cand_valid[0] = 0;
    @(negedge clk); expect_sel(3'd0, 4'h8, "R8 invalid held");
    forced_idx = 3'd5;
    @(negedge clk); expect_sel(3'd4, 4'hB, "R8 out of range");
    manual_mode = 0;
    @(negedge clk); expect_sel(3'd1, 4'h2, "R8 back to auto");

    // R1 reset mid-run
    rst = 1;
    @(negedge clk);
    chk(sel_idx == 3'd4 && sel_local, "R1 mid reset", sel_idx, 4);
    chk(sel_change == 1'b0, "R1 mid reset pulse", sel_change, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule